// File: doc/BRIEF.md
# Scratchpad Page Memory Command Controller

This block runs the memory-side commands of a small battery identification device once the bus layer has selected it. A byte-wide front end hands it the command byte, then an address and write data, and it returns read bytes when asked. Behind it sit three scratchpad pages, each paired with a backing store: two that stand for nonvolatile cells and one volatile. It also holds a register page and an identity/counter page. A master never writes backing storage directly. It fills a scratchpad, reads it back to verify it, and then issues a whole-page copy.

Scratchpad reads end with a CRC byte covering every byte streamed. Page one can be write-protected. A busy flag models the slow nonvolatile write time and paces copies, lock changes and cycle-counter updates. Temperature and voltage results come in on simple done/value inputs that stand in for the converters.

Top module: `sp_mem_ctrl`

## Requirements
- R1: After `rst_ni` is released, all scratchpad and backing bytes, the temperature, voltage and counter registers, and all status flags are zero.
- R2: Scratchpad page n (n = 1..3) spans address 20h*(n-1) to 20h*(n-1)+1Fh. It holds 24, 8 and 8 usable bytes from offset 0. Unused offsets, and scratchpad reads that start at 60h or above, return FFh. Writes to unused offsets have no effect.
- R3: Command 11h plus an address streams bytes from that address up to offset 1Fh of its page. The next byte is the CRC-8 of all bytes sent, computed LSB first with polynomial x8+x5+x4+1 (reflected 8Ch) from an initial value of 0. Every later byte is FFh until a frame reset.
- R4: Command 17h plus an address stores the following bytes at rising addresses up to offset 1Fh of that page. Any bytes after that are dropped and never reach the next page.
- R5: Commands 22h, 25h and 28h copy a whole scratchpad page (1, 2, 3) into its backing store. Commands 71h, 77h and 7Ah copy a whole backing store back into its scratchpad. None of these commands takes an address.
- R6: Command 43h locks page 1 and 44h unlocks it. While locked, 22h is refused and does not set the busy flag, but 71h still works.
- R7: The busy flag is set for NV_BUSY_CYC cycles after an accepted 22h, 25h, 43h, 44h, B5h or B8h. Any of these six commands that arrives while the flag is set is ignored.
- R8: Status byte 62h reads as {4'b0000, voltage busy, lock, nv busy, temperature busy}, with temperature busy at bit 0. Byte 63h reads as FFh.
- R9: Command B2h plus an address reads registers. The layout is: 60h/61h temperature low/high; 62h/63h status; 77h/78h voltage low/high; 80h/81h MFG_ID low/high; 82h/83h counter low/high; every other address gives FFh. The stream stops after 63h, 78h, 83h or offset 1Fh of a page, and then returns FFh.
- R10: B5h adds one to the CYC_W-bit cycle counter and holds it at all ones once it gets there. B8h clears the counter.
- R11: D2h sets temperature busy and B4h sets voltage busy, but only when neither conversion is running. A done pulse loads the value and clears the flag only while that flag is set.
- R12: Only the first byte after `frame_rst_i` is taken as a command. Later bytes of a one-byte command are ignored. Each `rd_req_i` gives `rd_valid_o` with a byte on the next cycle, and that byte is FFh outside a read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_rst_i | input | 1 | Bus reset seen; next byte is a command |
| wr_valid_i | input | 1 | Byte from master valid |
| wr_data_i | input | 8 | Byte from master |
| rd_req_i | input | 1 | Master requests a byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| t_done_i | input | 1 | Temperature result ready |
| t_value_i | input | 16 | Temperature result |
| v_done_i | input | 1 | Voltage result ready |
| v_value_i | input | 16 | Voltage result |

## Verification
The assertions assume the following about the inputs:
- Converter done pulses are the only way a conversion flag can clear.
- Nonvolatile activity starts only from a byte handed in on `wr_valid_i`.
- Read strobes are single-cycle requests.

Under these conditions the counter can only step up by one, clear, or stay saturated. The stimulus keeps to this by pulsing `t_done_i` and `v_done_i` for one cycle at a time and by driving bytes and read requests as one-cycle strobes. It also waits out the busy window before issuing each nonvolatile command it expects to be accepted, and only issues one during the window when it is checking that the command is ignored.

// File: rtl/sp_mem_pkg.sv
package sp_mem_pkg;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_WR, ST_RD, ST_RDC, ST_REG, ST_DONE
  } state_e;

  localparam logic [7:0] CMD_RD_SP   = 8'h11;
  localparam logic [7:0] CMD_WR_SP   = 8'h17;
  localparam logic [7:0] CMD_ST_P1   = 8'h22;
  localparam logic [7:0] CMD_ST_P2   = 8'h25;
  localparam logic [7:0] CMD_ST_P3   = 8'h28;
  localparam logic [7:0] CMD_LD_P1   = 8'h71;
  localparam logic [7:0] CMD_LD_P2   = 8'h77;
  localparam logic [7:0] CMD_LD_P3   = 8'h7A;
  localparam logic [7:0] CMD_LOCK    = 8'h43;
  localparam logic [7:0] CMD_UNLOCK  = 8'h44;
  localparam logic [7:0] CMD_RD_REG  = 8'hB2;
  localparam logic [7:0] CMD_CNT_INC = 8'hB5;
  localparam logic [7:0] CMD_CNT_CLR = 8'hB8;
  localparam logic [7:0] CMD_CONV_T  = 8'hD2;
  localparam logic [7:0] CMD_CONV_V  = 8'hB4;

  // reflected x8+x5+x4+1, LSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

endpackage

// File: rtl/page_bank.sv
module page_bank #(
  parameter int BYTES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sp_we_i,
  input  logic [4:0] off_i,
  input  logic [7:0] wdata_i,
  input  logic       to_back_i,
  input  logic       from_back_i,
  output logic [7:0] rdata_o
);
  logic [7:0] spad_q [BYTES];
  logic [7:0] back_q [BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) begin
        spad_q[i] <= '0;
        back_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < BYTES; i++) begin
        if (from_back_i) spad_q[i] <= back_q[i];
        else if (sp_we_i && off_i == 5'(i)) spad_q[i] <= wdata_i;
        if (to_back_i) back_q[i] <= spad_q[i];
      end
    end
  end

  always_comb begin
    rdata_o = 8'hFF;
    for (int i = 0; i < BYTES; i++)
      if (off_i == 5'(i)) rdata_o = spad_q[i];
  end
endmodule

// File: rtl/nv_busy.sv
module nv_busy #(
  parameter int CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i && cnt_q == '0)  cnt_q <= CW'(CYC);
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sp_mem_ctrl.sv
module sp_mem_ctrl import sp_mem_pkg::*; #(
  parameter int          P1_BYTES    = 24,
  parameter int          P2_BYTES    = 8,
  parameter int          P3_BYTES    = 8,
  parameter int          NV_BUSY_CYC = 2000,
  parameter int          CYC_W       = 16,
  parameter logic [15:0] MFG_ID      = 16'h5A3C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_rst_i,
  input  logic        wr_valid_i,
  input  logic [7:0]  wr_data_i,
  input  logic        rd_req_i,
  output logic        rd_valid_o,
  output logic [7:0]  rd_data_o,
  input  logic        t_done_i,
  input  logic [15:0] t_value_i,
  input  logic        v_done_i,
  input  logic [15:0] v_value_i
);
  localparam int PAGES = 3;

  state_e           state_q;
  logic [7:0]       addr_q, crc_q, rd_byte, reg_byte, sp_byte, status_b;
  logic             lock_q, tb_q, adb_q, nvb, nv_start;
  logic [15:0]      temp_q, volt_q, cyc16;
  logic [CYC_W-1:0] cyc_q;
  logic [PAGES-1:0] sp_we, to_back, from_back;
  logic [7:0]       pg_rdata [4];
  logic             cmd_fire, addr_end, reg_stop;

  assign cmd_fire = (state_q == ST_CMD) && wr_valid_i && !frame_rst_i;
  assign addr_end = (addr_q[4:0] == 5'h1F);

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    localparam int NB = (g == 0) ? P1_BYTES : (g == 1) ? P2_BYTES : P3_BYTES;
    assign sp_we[g] = (state_q == ST_WR) && wr_valid_i && !frame_rst_i &&
                      (addr_q[6:5] == 2'(g));
    page_bank #(.BYTES(NB)) u_bank (
      .clk_i, .rst_ni,
      .sp_we_i    (sp_we[g]),
      .off_i      (addr_q[4:0]),
      .wdata_i    (wr_data_i),
      .to_back_i  (to_back[g]),
      .from_back_i(from_back[g]),
      .rdata_o    (pg_rdata[g])
    );
  end
  assign pg_rdata[3] = 8'hFF;

  always_comb begin
    to_back = '0; from_back = '0; nv_start = 1'b0;
    if (cmd_fire) begin
      case (wr_data_i)
        CMD_ST_P1: if (!nvb && !lock_q) begin to_back[0] = 1'b1; nv_start = 1'b1; end
        CMD_ST_P2: if (!nvb) begin to_back[1] = 1'b1; nv_start = 1'b1; end
        CMD_ST_P3: to_back[2] = 1'b1;
        CMD_LD_P1: from_back[0] = 1'b1;
        CMD_LD_P2: from_back[1] = 1'b1;
        CMD_LD_P3: from_back[2] = 1'b1;
        CMD_LOCK, CMD_UNLOCK, CMD_CNT_INC, CMD_CNT_CLR: nv_start = !nvb;
        default: ;
      endcase
    end
  end

  nv_busy #(.CYC(NV_BUSY_CYC)) u_busy (
    .clk_i, .rst_ni, .start_i(nv_start), .busy_o(nvb)
  );

  assign cyc16    = 16'(cyc_q);
  assign status_b = {4'b0000, adb_q, lock_q, nvb, tb_q};
  assign sp_byte  = pg_rdata[addr_q[6:5]];
  assign reg_stop = addr_end || addr_q == 8'h63 || addr_q == 8'h78 || addr_q == 8'h83;

  always_comb begin
    case (addr_q)
      8'h60:   reg_byte = temp_q[7:0];
      8'h61:   reg_byte = temp_q[15:8];
      8'h62:   reg_byte = status_b;
      8'h77:   reg_byte = volt_q[7:0];
      8'h78:   reg_byte = volt_q[15:8];
      8'h80:   reg_byte = MFG_ID[7:0];
      8'h81:   reg_byte = MFG_ID[15:8];
      8'h82:   reg_byte = cyc16[7:0];
      8'h83:   reg_byte = cyc16[15:8];
      default: reg_byte = 8'hFF;
    endcase
    case (state_q)
      ST_RD:   rd_byte = sp_byte;
      ST_RDC:  rd_byte = crc_q;
      ST_REG:  rd_byte = reg_byte;
      default: rd_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CMD;
      addr_q     <= '0;
      crc_q      <= '0;
      lock_q     <= 1'b0;
      tb_q       <= 1'b0;
      adb_q      <= 1'b0;
      temp_q     <= '0;
      volt_q     <= '0;
      cyc_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= 8'hFF;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) rd_data_o <= rd_byte;

      if (tb_q && t_done_i) begin temp_q <= t_value_i; tb_q <= 1'b0; end
      if (adb_q && v_done_i) begin volt_q <= v_value_i; adb_q <= 1'b0; end

      if (cmd_fire) begin
        case (wr_data_i)
          CMD_LOCK:    if (!nvb) lock_q <= 1'b1;
          CMD_UNLOCK:  if (!nvb) lock_q <= 1'b0;
          CMD_CNT_INC: if (!nvb && cyc_q != '1) cyc_q <= cyc_q + 1'b1;
          CMD_CNT_CLR: if (!nvb) cyc_q <= '0;
          CMD_CONV_T:  if (!tb_q && !adb_q) tb_q <= 1'b1;
          CMD_CONV_V:  if (!tb_q && !adb_q) adb_q <= 1'b1;
          default: ;
        endcase
      end

      if (frame_rst_i) begin
        state_q <= ST_CMD;
      end else begin
        case (state_q)
          ST_CMD: if (wr_valid_i) begin
            addr_q <= wr_data_i;
            if (wr_data_i == CMD_RD_SP || wr_data_i == CMD_WR_SP || wr_data_i == CMD_RD_REG)
              state_q <= ST_ADDR;
            else
              state_q <= ST_DONE;
          end
          ST_ADDR: if (wr_valid_i) begin
            addr_q <= wr_data_i;
            crc_q  <= '0;
            if (addr_q == CMD_RD_REG)  state_q <= ST_REG;
            else if (wr_data_i >= 8'h60) state_q <= ST_DONE;
            else state_q <= (addr_q == CMD_RD_SP) ? ST_RD : ST_WR;
          end
          ST_WR: if (wr_valid_i) begin
            addr_q <= addr_q + 1'b1;
            if (addr_end) state_q <= ST_DONE;
          end
          ST_RD: if (rd_req_i) begin
            crc_q  <= crc8_step(crc_q, sp_byte);
            addr_q <= addr_q + 1'b1;
            if (addr_end) state_q <= ST_RDC;
          end
          ST_RDC: if (rd_req_i) state_q <= ST_DONE;
          ST_REG: if (rd_req_i) begin
            addr_q <= addr_q + 1'b1;
            if (reg_stop) state_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sp_mem_ctrl_chk.sv
module sp_mem_ctrl_chk #(
  parameter int CYC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             rd_req_i,
  input logic             rd_valid_o,
  input logic             t_done_i,
  input logic             v_done_i,
  input logic             tb_q,
  input logic             adb_q,
  input logic             nvb,
  input logic [CYC_W-1:0] cyc_q
);
  // R11
  conv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tb_q && adb_q));
  // R11
  tb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tb_q) |-> $past(t_done_i));
  // R11
  adb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adb_q) |-> $past(v_done_i));
  // R7
  nvb_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nvb) |-> $past(wr_valid_i));
  // R10
  cyc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != $past(cyc_q)) |-> (cyc_q == CYC_W'($past(cyc_q) + 1'b1) || cyc_q == '0));
  // R10
  cyc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cyc_q) == '1 && cyc_q != '0) |-> cyc_q == '1);
  // R12
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));
endmodule

bind sp_mem_ctrl sp_mem_ctrl_chk #(.CYC_W(CYC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .rd_req_i(rd_req_i),
  .rd_valid_o(rd_valid_o), .t_done_i(t_done_i), .v_done_i(v_done_i),
  .tb_q(tb_q), .adb_q(adb_q), .nvb(nvb), .cyc_q(cyc_q)
);

// File: tb/sp_mem_ctrl_test.sv
module sp_mem_ctrl_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          NV_CYC     = 20;
  localparam int          CW         = 4;
  localparam logic [15:0] MFG        = 16'hC3A5;

  logic clk = 1'b0, rst_ni = 1'b0, frame_rst = 1'b0;
  logic wr_valid = 1'b0, rd_req = 1'b0, t_done = 1'b0, v_done = 1'b0;
  logic [7:0] wr_data = '0;
  logic [15:0] t_value = '0, v_value = '0;
  logic rd_valid;
  logic [7:0] rd_data;

  sp_mem_ctrl #(.NV_BUSY_CYC(NV_CYC), .CYC_W(CW), .MFG_ID(MFG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_rst_i(frame_rst),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .rd_req_i(rd_req),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .t_done_i(t_done), .t_value_i(t_value), .v_done_i(v_done), .v_value_i(v_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m_sp [40];
  logic [7:0] m_bk [40];

  function automatic int pbase(int p); return (p == 0) ? 0 : (p == 1) ? 24 : 32; endfunction
  function automatic int psize(int p); return (p == 0) ? 24 : 8; endfunction

  function automatic logic [7:0] exp_sp(logic [7:0] a);
    int p, o;
    if (a >= 8'h60) return 8'hFF;
    p = int'(a[6:5]); o = int'(a[4:0]);
    return (o < psize(p)) ? m_sp[pbase(p) + o] : 8'hFF;
  endfunction

  function automatic logic [7:0] crc_bit_loop(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", r, act, exp);
    end
  endtask

  task automatic frame();
    @(negedge clk); frame_rst = 1'b1;
    @(negedge clk); frame_rst = 1'b0;
  endtask

  task automatic send(logic [7:0] b);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; b = rd_data;
  endtask

  task automatic cmd(logic [7:0] c); frame(); send(c); endtask
  task automatic wait_nv(); repeat (NV_CYC + 3) @(negedge clk); endtask

  task automatic reg_is(string r, logic [7:0] a, logic [7:0] exp);
    logic [7:0] b;
    frame(); send(8'hB2); send(a); rd(b); chk(r, b, exp);
  endtask

  task automatic wr_sp(logic [7:0] a, int n);
    logic [7:0] d;
    int o;
    frame(); send(8'h17); send(a);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send(d);
      o = int'(a[4:0]) + k;
      if (a < 8'h60 && o <= 31 && o < psize(int'(a[6:5]))) m_sp[pbase(int'(a[6:5])) + o] = d;
    end
  endtask

  task automatic rd_page(string r, logic [7:0] a);
    logic [7:0] b, e, c;
    c = '0;
    frame(); send(8'h11); send(a);
    for (int o = int'(a[4:0]); o < 32; o++) begin
      e = exp_sp({a[7:5], 5'(o)});
      rd(b); chk(r, b, e);
      c = crc_bit_loop(c, e);
    end
    rd(b); chk({r, " crc"}, b, c);
    rd(b); chk({r, " tail"}, b, 8'hFF);
    rd(b); chk({r, " tail"}, b, 8'hFF);
  endtask

  task automatic page_copy(int p, logic [7:0] to_cmd, logic [7:0] from_cmd);
    wr_sp(8'(p * 32), psize(p));
    cmd(to_cmd);
    for (int i = 0; i < psize(p); i++) m_bk[pbase(p) + i] = m_sp[pbase(p) + i];
    wait_nv();
    wr_sp(8'(p * 32), psize(p));
    cmd(from_cmd);
    for (int i = 0; i < psize(p); i++) m_sp[pbase(p) + i] = m_bk[pbase(p) + i];
    rd_page("R5 copy round trip", 8'(p * 32));
  endtask

  task automatic pulse_t(logic [15:0] v);
    @(negedge clk); t_value = v; t_done = 1'b1;
    @(negedge clk); t_done = 1'b0;
  endtask

  task automatic pulse_v(logic [15:0] v);
    @(negedge clk); v_value = v; v_done = 1'b1;
    @(negedge clk); v_done = 1'b0;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd4242));
    for (int i = 0; i < 40; i++) begin m_sp[i] = '0; m_bk[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    reg_is("R1 status", 8'h62, 8'h00);
    reg_is("R1 temp", 8'h60, 8'h00);
    reg_is("R1 volt", 8'h77, 8'h00);
    reg_is("R1 counter", 8'h82, 8'h00);
    rd_page("R1 scratch zero", 8'h00);
    cmd(8'h7A);
    rd_page("R1 backing zero", 8'h40);

    // R2 reads above scratch space
    frame(); send(8'h11); send(8'h60);
    rd(b); chk("R2 high addr", b, 8'hFF);
    rd(b); chk("R2 high addr", b, 8'hFF);

    // R4 no wrap into next page
    wr_sp(8'h1F, 3);
    wr_sp(8'h3E, 4);
    rd_page("R4 page1 tail", 8'h00);
    rd_page("R4 page2 untouched", 8'h20);
    rd_page("R4 page3 untouched", 8'h40);

    // R2 R3 R4 random traffic
    for (int it = 0; it < 25; it++) begin
      int p, o, n;
      p = int'($urandom % 3); o = int'($urandom % 32); n = 1 + int'($urandom % 36);
      wr_sp(8'(p * 32 + o), n);
      rd_page("R3 stream", 8'(p * 32 + int'($urandom % 32)));
    end

    // R5 copies
    page_copy(0, 8'h22, 8'h71);
    page_copy(1, 8'h25, 8'h77);
    page_copy(2, 8'h28, 8'h7A);

    // R6 lock
    cmd(8'h43); wait_nv();
    reg_is("R6 locked", 8'h62, 8'h04);
    wr_sp(8'h00, 24);
    cmd(8'h22);
    reg_is("R6 refused no busy", 8'h62, 8'h04);
    cmd(8'h71);
    for (int i = 0; i < 24; i++) m_sp[i] = m_bk[i];
    rd_page("R6 load while locked", 8'h00);
    cmd(8'h44); wait_nv();
    reg_is("R6 unlocked", 8'h62, 8'h00);

    // R7 busy window
    cmd(8'h25);
    for (int i = 0; i < 8; i++) m_bk[24 + i] = m_sp[24 + i];
    cmd(8'hB5);
    reg_is("R7 busy set", 8'h62, 8'h02);
    wait_nv();
    reg_is("R7 busy clear", 8'h62, 8'h00);
    reg_is("R7 inc ignored", 8'h82, 8'h00);

    // R10 counter
    for (int i = 0; i < 3; i++) begin cmd(8'hB5); wait_nv(); end
    reg_is("R10 count", 8'h82, 8'h03);
    for (int i = 0; i < 16; i++) begin cmd(8'hB5); wait_nv(); end
    reg_is("R10 saturate", 8'h82, 8'h0F);
    reg_is("R10 high", 8'h83, 8'h00);
    cmd(8'hB8); wait_nv();
    reg_is("R10 clear", 8'h82, 8'h00);

    // R11 conversions, R8 status layout
    cmd(8'hD2);
    reg_is("R8 tb bit0", 8'h62, 8'h01);
    cmd(8'hB4);
    reg_is("R11 v blocked", 8'h62, 8'h01);
    pulse_t(16'h1910);
    reg_is("R11 tb clear", 8'h62, 8'h00);
    reg_is("R11 temp lo", 8'h60, 8'h10);
    reg_is("R11 temp hi", 8'h61, 8'h19);
    pulse_t(16'h7777);
    reg_is("R11 stray done", 8'h60, 8'h10);
    cmd(8'hB4);
    reg_is("R8 adb bit3", 8'h62, 8'h08);
    cmd(8'hD2);
    reg_is("R11 t blocked", 8'h62, 8'h08);
    pulse_v(16'h01F4);
    reg_is("R11 volt lo", 8'h77, 8'hF4);
    reg_is("R11 volt hi", 8'h78, 8'h01);
    cmd(8'h43); cmd(8'hD2);
    reg_is("R8 combined", 8'h62, 8'h07);
    pulse_t(16'h0080);
    wait_nv();
    cmd(8'h44); wait_nv();

    // R9 register streams
    frame(); send(8'hB2); send(8'h60);
    rd(b); chk("R9 60", b, 8'h80);
    rd(b); chk("R9 61", b, 8'h00);
    rd(b); chk("R9 62", b, 8'h00);
    rd(b); chk("R8 63", b, 8'hFF);
    rd(b); chk("R9 past 63", b, 8'hFF);
    frame(); send(8'hB2); send(8'h80);
    rd(b); chk("R9 mfg lo", b, MFG[7:0]);
    rd(b); chk("R9 mfg hi", b, MFG[15:8]);
    rd(b); chk("R9 cnt lo", b, 8'h00);
    rd(b); chk("R9 cnt hi", b, 8'h00);
    rd(b); chk("R9 past 83", b, 8'hFF);
    frame(); send(8'hB2); send(8'h7E);
    rd(b); chk("R9 7E", b, 8'hFF);
    rd(b); chk("R9 7F", b, 8'hFF);
    rd(b); chk("R9 no cross", b, 8'hFF);
    reg_is("R9 scratch addr", 8'h40, 8'hFF);

    // R12 framing
    wr_sp(8'h40, 8);
    cmd(8'h28);
    for (int i = 0; i < 8; i++) m_bk[32 + i] = m_sp[32 + i];
    wr_sp(8'h40, 8);
    frame(); send(8'h7A); send(8'h17); send(8'h40); send(8'h55);
    for (int i = 0; i < 8; i++) m_sp[32 + i] = m_bk[32 + i];
    rd_page("R12 extra bytes ignored", 8'h40);
    frame(); rd(b); chk("R12 idle read", b, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule